// File: doc/BRIEF.md
# Key Input Port Interrupt Unit

This block serves a small general-purpose key input port. It brings the raw key pins into the clock domain through a synchronizer chain and returns their levels on a simple register bus. It also raises one shared interrupt when any enabled key goes high. Each key has its own enable bit. A single sticky flag records the event, drives the interrupt request output, and clears itself when software reads it.

An optional noise filter makes the interrupt condition wait until it has held for a programmable number of clock cycles. A separate detector watches a fixed group of keys. When every key in that group has been high for a long, parameterised hold time, it raises a reset request. The group is chosen when the block is built: no group, keys 0 and 1, keys 0 to 2, or all four keys.

Top module: `keyport_irq`

## Requirements
- R1: A read at address 0xE0 returns the synchronized pin levels, bit i for pin i. A read at any address other than 0xE0, 0xE8 or 0xED returns 0. Read data appears on `bus_rdata_o` one cycle after the read strobe.
- R2: Writes to address 0xE0 and to address 0xED change no state. The enable register and the flag keep their values.
- R3: The enable register sits at address 0xE8. It can be read and written. Bit i set to 1 enables pin i, and a pin whose enable bit is 0 never sets the flag.
- R4: The flag is set when the OR of (synchronized pins AND enables) rises, taken after the filter. `irq_o` is the flag.
- R5: The flag reads at address 0xED bit 0, and bits 3 to 1 there read 0. Reading that address clears the flag. If a set and a read fall in the same cycle, the flag stays set.
- R6: A key that stays high sets the flag only once. Clearing its enable bit and then setting it again while the key is still high sets the flag again.
- R7: With filtering built in, the condition must hold for FILT_CYCLES consecutive cycles before it counts. A shorter pulse never sets the flag.
- R8: `rst_req_o` rises once every pin in the selected group has been high for HOLD_CYCLES consecutive cycles. It falls within a few cycles of any pin in the group going low. A partial group never raises it.
- R9: After reset the enable register, the flag, `irq_o` and `rst_req_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NBITS | Raw key pin levels |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | NBITS | Write data |
| bus_rdata_o | output | NBITS | Registered read data |
| irq_o | output | 1 | Interrupt request (the flag) |
| rst_req_o | output | 1 | Multi-key hold reset request |

## Verification
The bench builds the block with FILT_CYCLES=8, HOLD_CYCLES=50 and the three-key reset group (RST_COMBO=2). At the default values the filter and hold windows are far too long to exercise. With these short windows, the bench can test a pulse that is shorter than the filter, a full hold of the key group, a hold that is cut short, and a hold of only two of the three keys. The bench runs these cases with an enabled key, with a disabled key, and with the enable register rewritten while a key stays high.

// File: rtl/kp_pkg.sv
package kp_pkg;
  // Group selector for the multi-key hold reset
  localparam int COMBO_NONE  = 0;
  localparam int COMBO_TWO   = 1;
  localparam int COMBO_THREE = 2;
  localparam int COMBO_FOUR  = 3;

  // Bit mask of the keys that must all be high
  function automatic int combo_mask(input int sel);
    if (sel <= COMBO_NONE) return 0;
    return (1 << (sel + 1)) - 1;
  endfunction
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[s] <= '0;
      else     st[s] <= st[s-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/kp_filter.sv
module kp_filter #(
  parameter bit FILT_EN     = 1'b1,
  parameter int FILT_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic cond_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);

  if (FILT_EN) begin : g_filt
    logic [CW-1:0] cnt_q;
    logic          filt_q;

    always_ff @(posedge clk) begin
      if (rst || !cond_i) begin
        cnt_q  <= '0;
        filt_q <= 1'b0;
      end else if (cnt_q >= CW'(FILT_CYCLES - 1)) begin
        filt_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign filt_o = filt_q;

    AST_FILT_BLOCK: assert property (@(posedge clk) disable iff (rst)
      !cond_i |=> !filt_o); // R7
  end else begin : g_pass
    assign filt_o = cond_i;
  end
endmodule

// File: rtl/kp_hold.sv
module kp_hold #(
  parameter int NBITS       = 4,
  parameter int RST_COMBO   = 3,
  parameter int HOLD_CYCLES = 2000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] keys_i,
  output logic             rst_req_o
);
  localparam logic [NBITS-1:0] CMASK = NBITS'(kp_pkg::combo_mask(RST_COMBO));
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic          all_hi;
  logic [CW-1:0] cnt_q;
  logic          req_q;

  assign all_hi = (CMASK != '0) && ((keys_i & CMASK) == CMASK);

  always_ff @(posedge clk) begin
    if (rst || !all_hi) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (cnt_q >= CW'(HOLD_CYCLES - 1)) begin
      req_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rst_req_o = req_q;

  AST_RST_NEEDS_KEYS: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(all_hi)); // R8
  AST_RST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !all_hi |=> !rst_req_o); // R8
endmodule

// File: rtl/keyport_irq.sv
module keyport_irq #(
  parameter int              NBITS       = 4,
  parameter int              ADDR_W      = 8,
  parameter int              SYNC_STAGES = 2,
  parameter bit              FILT_EN     = 1'b1,
  parameter int              FILT_CYCLES = 1000,
  parameter int              RST_COMBO   = 3,
  parameter int              HOLD_CYCLES = 2000000,
  parameter logic [ADDR_W-1:0] ADDR_DATA = 8'hE0,
  parameter logic [ADDR_W-1:0] ADDR_EN   = 8'hE8,
  parameter logic [ADDR_W-1:0] ADDR_FLAG = 8'hED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NBITS-1:0]  pin_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NBITS-1:0]  bus_wdata_i,
  output logic [NBITS-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic [NBITS-1:0] keys;
  logic [NBITS-1:0] en_q;
  logic             cond, filt, filt_d, rise;
  logic             flag_q;
  logic             rd_stb, wr_stb, rd_flag;
  logic [NBITS-1:0] rdata_q;

  kp_sync #(.W(NBITS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(keys));

  assign cond = |(keys & en_q);

  kp_filter #(.FILT_EN(FILT_EN), .FILT_CYCLES(FILT_CYCLES)) filt_i (
    .clk(clk), .rst(rst), .cond_i(cond), .filt_o(filt));

  kp_hold #(.NBITS(NBITS), .RST_COMBO(RST_COMBO), .HOLD_CYCLES(HOLD_CYCLES)) hold_i (
    .clk(clk), .rst(rst), .keys_i(keys), .rst_req_o(rst_req_o));

  assign rd_stb  = bus_sel_i && !bus_wr_i;
  assign wr_stb  = bus_sel_i && bus_wr_i;
  assign rd_flag = rd_stb && (bus_addr_i == ADDR_FLAG);
  assign rise    = filt && !filt_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      filt_d <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      filt_d <= filt;
      if (wr_stb && bus_addr_i == ADDR_EN) en_q <= bus_wdata_i;
      if (rise)         flag_q <= 1'b1;
      else if (rd_flag) flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_stb) begin
      if (bus_addr_i == ADDR_DATA)      rdata_q <= keys;
      else if (bus_addr_i == ADDR_EN)   rdata_q <= en_q;
      else if (bus_addr_i == ADDR_FLAG) rdata_q <= NBITS'(flag_q);
      else                              rdata_q <= '0;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    rise |=> irq_o); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_flag && !rise) |=> !irq_o); // R5
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && bus_addr_i == ADDR_EN) |=> en_q == $past(bus_wdata_i)); // R3
  AST_FLAG_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_flag) |-> bus_rdata_o[NBITS-1:1] == '0); // R5
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(rise)); // R4
endmodule

// File: tb/keyport_irq_tb.sv
module keyport_irq_tb_top;
  localparam int FILT = 8;
  localparam int HOLD = 50;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pin = '0;
  logic       sel = 1'b0, wr = 1'b0;
  logic [7:0] addr = '0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic       irq, rreq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  keyport_irq #(.FILT_CYCLES(FILT), .RST_COMBO(2), .HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rst(rst), .pin_i(pin), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .rst_req_o(rreq));

  function automatic logic [3:0] exp_read(input logic [7:0] a, input logic [3:0] p,
                                          input logic [3:0] e, input logic f);
    if (a == 8'hE0) return p;
    if (a == 8'hE8) return e;
    if (a == 8'hED) return {3'b000, f};
    return 4'h0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [3:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0; d = rdata;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [3:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [3:0] d;
    logic [3:0] en;
    logic [7:0] a;
    void'($urandom(32'd7));
    wait_cyc(4);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 irq", irq, 0);
    check("R9 rst_req", rreq, 0);
    bus_read(8'hE8, d); check("R9 enable", d, 0);
    bus_read(8'hED, d); check("R9 flag", d, 0);

    // Random readback of pins, enables and unmapped space (R1, R3)
    en = 4'h0;
    for (int i = 0; i < 40; i++) begin
      pin = 4'($urandom());
      en  = 4'($urandom());
      bus_write(8'hE8, en);
      wait_cyc(2);
      bus_read(8'hE0, d); check("R1 pin readback", d, exp_read(8'hE0, pin, en, 1'b0));
      bus_read(8'hE8, d); check("R3 enable readback", d, exp_read(8'hE8, pin, en, 1'b0));
      do a = 8'($urandom()); while (a == 8'hE0 || a == 8'hE8 || a == 8'hED);
      bus_read(a, d); check("R1 unmapped read", d, exp_read(a, pin, en, 1'b0));
    end

    // Quiet state
    pin = 4'h0;
    bus_write(8'hE8, 4'h0);
    wait_cyc(FILT + 6);
    bus_read(8'hED, d);
    check("R5 flag idle", irq, 0);

    // R3: disabled key does not set the flag
    bus_write(8'hE8, 4'b1101);
    pin = 4'b0010;
    wait_cyc(FILT + 8);
    check("R3 masked key", irq, 0);

    // R4: enabled key sets flag
    pin = 4'b0110;
    wait_cyc(FILT + 8);
    check("R4 irq set", irq, 1);
    // R2: writes to data and flag addresses ignored
    bus_write(8'hED, 4'h0);
    bus_write(8'hE0, 4'hF);
    check("R2 flag kept", irq, 1);
    bus_read(8'hE8, d); check("R2 enable kept", d, 4'b1101);
    // R5: read returns 1 with zero upper bits, then clears
    bus_read(8'hED, d); check("R5 flag read", d, 4'b0001);
    check("R5 cleared", irq, 0);
    bus_read(8'hED, d); check("R5 reread", d, 0);
    // R6: held key does not set again
    wait_cyc(FILT + 8);
    check("R6 no retrigger", irq, 0);
    // R6: enable rewrite while key high sets again
    bus_write(8'hE8, 4'h0);
    wait_cyc(3);
    bus_write(8'hE8, 4'b0100);
    wait_cyc(FILT + 8);
    check("R6 rewrite sets", irq, 1);
    bus_read(8'hED, d);
    pin = 4'h0;
    wait_cyc(4);

    // R7: short pulse filtered, long pulse passes
    bus_write(8'hE8, 4'b1000);
    pin = 4'b1000;
    wait_cyc(FILT / 2);
    pin = 4'h0;
    wait_cyc(FILT + 8);
    check("R7 short pulse", irq, 0);
    pin = 4'b1000;
    wait_cyc(FILT - 4);
    check("R7 before window", irq, 0);
    wait_cyc(10);
    check("R7 after window", irq, 1);
    bus_read(8'hED, d);
    pin = 4'h0;
    bus_write(8'hE8, 4'h0);

    // R8: hold reset on keys 0..2
    pin = 4'b0011;
    wait_cyc(HOLD + 20);
    check("R8 partial group", rreq, 0);
    pin = 4'b0111;
    wait_cyc(HOLD / 2);
    check("R8 early", rreq, 0);
    pin = 4'b0011;
    wait_cyc(2);
    pin = 4'b0111;
    wait_cyc(HOLD - 10);
    check("R8 restarted", rreq, 0);
    wait_cyc(20);
    check("R8 asserted", rreq, 1);
    pin = 4'b0110;
    wait_cyc(5);
    check("R8 release", rreq, 0);

    finish_run();
  end
endmodule